// File: doc/BRIEF.md
# Keyboard Serial Link Host Receiver

This block is the receive side of a host controller for a two-wire, open-drain keyboard link. Both lines idle high. The device sends frames of eleven bits: a low start bit, eight data bits sent least significant bit first, an odd-parity bit, and a high stop bit. The device changes data while its clock is high, and the host samples data on each falling clock edge. The block reads both lines through synchronizers. For each line it has a drive-low enable output, which the pad logic uses to pull that line to ground.

Between frames the block holds the clock line low. This stops the device from sending, and the device keeps its keystrokes buffered. A single-cycle `arm` request releases the clock, and the block then waits for a start bit. A low clock with data high is a false start, and the block keeps waiting. A good frame produces a one-cycle `rx_valid` strobe with the byte held on `rx_byte`. If the parity bit or the stop bit is wrong, the block discards the frame and raises `rx_err`. It also pulses `resend_req`, together with the command code on `resend_code`, to a companion transmitter. It then holds the clock low for a guard interval and starts listening again by itself. If the clock stalls in the middle of a frame, a timeout ends the frame with an error and no resend.

The states are INHIBIT, LISTEN, SHIFT, PARITY, STOP and REARM. The transitions are:
- INHIBIT to LISTEN on `arm`.
- LISTEN to SHIFT on a falling edge with data low.
- SHIFT to PARITY after the eighth data edge.
- PARITY to STOP when parity is good, or PARITY to REARM when it is bad.
- STOP to INHIBIT when the stop bit is high, or STOP to REARM when it is low.
- SHIFT, PARITY or STOP to INHIBIT on a timeout.
- REARM to LISTEN when the guard interval ends.

Top module: `ps2rx_engine`

## Requirements
- R1: After reset, `kclk_drv_low` is 1. It stays 1 until an `arm` pulse arrives.
- R2: One cycle of `arm` in INHIBIT releases the clock: `kclk_drv_low` goes to 0 on the next clock edge.
- R3: A falling clock edge while data is high, seen while listening, is a false start. It is ignored: no strobe, no error, and the clock stays released.
- R4: The eight data bits are sampled on successive falling edges of the device clock. The first bit sampled becomes bit 0 of `rx_byte`.
- R5: The parity bit must make the count of ones across the data bits and the parity bit odd. On a mismatch the frame is dropped, and `rx_err` and `resend_req` pulse together with `err_kind` = 2'b01.
- R6: A low stop bit causes `rx_err` and `resend_req` to pulse, with `err_kind` = 2'b10, and no `rx_valid`.
- R7: After a parity or stop error, `kclk_drv_low` stays 1 for GAP_CYCLES clocks. It then returns to 0 without any `arm` pulse. `resend_code` is 8'hFE.
- R8: A good frame gives `rx_valid` high for exactly one cycle. `rx_byte` changes only with the strobe. The clock is pulled low at the strobe and stays low until the next `arm`.
- R9: If no falling edge arrives for TMO_CYCLES clocks after the start bit, `rx_err` pulses with `err_kind` = 2'b11 and no `resend_req`. The clock stays held low until `arm`.
- R10: `kdat_drv_low` is always 0. The receive path never drives the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Single-cycle request to accept one frame |
| kclk_in | input | 1 | Raw level of the device clock line |
| kdat_in | input | 1 | Raw level of the device data line |
| kclk_drv_low | output | 1 | Pull the clock line low when 1 |
| kdat_drv_low | output | 1 | Pull the data line low when 1 (always 0) |
| rx_byte | output | DATA_BITS | Last good byte, held between strobes |
| rx_valid | output | 1 | One-cycle strobe for a good frame |
| rx_err | output | 1 | One-cycle strobe for an aborted frame |
| err_kind | output | 2 | Cause of the last error: 01 parity, 10 stop, 11 timeout |
| resend_req | output | 1 | One-cycle request to transmit the resend command |
| resend_code | output | DATA_BITS | Command byte for the companion transmitter (8'hFE) |

## Verification
A wrong state shows up mostly on `kclk_drv_low`. If the clock is released too early, or never released, the level at the port is wrong on the edge after `arm`, at a strobe, or at the end of the guard interval. A bit-count or shift-order fault keeps the frame from ending at the right edge. It then shows up within one bit time, either as a wrong byte at the strobe or as a false parity error. A stuck REARM or a missed re-arm appears as no release within GAP_CYCLES after the error.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

    typedef enum logic [2:0] {
        ST_INHIBIT,
        ST_LISTEN,
        ST_SHIFT,
        ST_PARITY,
        ST_STOP,
        ST_REARM
    } ps2rx_state_t;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'b00,
        ERR_PARITY  = 2'b01,
        ERR_STOP    = 2'b10,
        ERR_TIMEOUT = 2'b11
    } ps2rx_err_t;

endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ps2rx_timer.sv
module ps2rx_timer #(
    parameter int LIMIT = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    assign expired = run && !clear && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (!run || clear)   cnt <= '0;
        else if (!expired)        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ps2rx_shift.sv
module ps2rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         take,
    input  logic         bit_in,
    output logic [W-1:0] data,
    output logic         ones_odd,
    output logic         last
);
    localparam int NW = (W > 1) ? $clog2(W) : 1;
    logic [NW-1:0] taken;

    assign last = (taken == NW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data     <= '0;
            ones_odd <= 1'b0;
            taken    <= '0;
        end else if (start) begin
            data     <= '0;
            ones_odd <= 1'b0;
            taken    <= '0;
        end else if (take) begin
            data     <= {bit_in, data[W-1:1]};
            ones_odd <= ones_odd ^ bit_in;
            taken    <= taken + 1'b1;
        end
    end
endmodule

// File: rtl/ps2rx_engine.sv
module ps2rx_engine
    import ps2rx_pkg::*;
#(
    parameter int          DATA_BITS   = 8,
    parameter int          SYNC_STAGES = 2,
    parameter int          TMO_CYCLES  = 5000,
    parameter int          GAP_CYCLES  = 5000,
    parameter logic [7:0]  RESEND_CMD  = 8'hFE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm,
    input  logic                 kclk_in,
    input  logic                 kdat_in,
    output logic                 kclk_drv_low,
    output logic                 kdat_drv_low,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 rx_err,
    output logic [1:0]           err_kind,
    output logic                 resend_req,
    output logic [DATA_BITS-1:0] resend_code
);
    ps2rx_state_t state, state_n;

    logic kclk_s, kdat_s, kclk_prev, fall;
    logic in_frame, tmo_hit, gap_done;
    logic sh_start, sh_take, sh_odd, sh_last;
    logic [DATA_BITS-1:0] sh_data;
    logic done_ok, bad_par, bad_stop, bad_tmo;

    ps2rx_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d(kclk_in), .q(kclk_s));
    ps2rx_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d(kdat_in), .q(kdat_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) kclk_prev <= 1'b1;
        else        kclk_prev <= kclk_s;
    end
    assign fall = kclk_prev & ~kclk_s;

    assign in_frame = (state == ST_SHIFT) || (state == ST_PARITY) || (state == ST_STOP);

    ps2rx_timer #(.LIMIT(TMO_CYCLES)) u_tmo (
        .clk(clk), .rst_n(rst_n), .run(in_frame), .clear(fall), .expired(tmo_hit));
    ps2rx_timer #(.LIMIT(GAP_CYCLES)) u_gap (
        .clk(clk), .rst_n(rst_n), .run(state == ST_REARM), .clear(1'b0), .expired(gap_done));

    ps2rx_shift #(.W(DATA_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .take(sh_take), .bit_in(kdat_s),
        .data(sh_data), .ones_odd(sh_odd), .last(sh_last));

    // next state and frame events
    always_comb begin
        state_n  = state;
        sh_start = 1'b0;
        sh_take  = 1'b0;
        done_ok  = 1'b0;
        bad_par  = 1'b0;
        bad_stop = 1'b0;
        bad_tmo  = 1'b0;
        unique case (state)
            ST_INHIBIT: begin
                if (arm) state_n = ST_LISTEN;
            end
            ST_LISTEN: begin
                if (fall && !kdat_s) begin
                    state_n  = ST_SHIFT;
                    sh_start = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (fall) begin
                    sh_take = 1'b1;
                    if (sh_last) state_n = ST_PARITY;
                end else if (tmo_hit) begin
                    bad_tmo = 1'b1;
                    state_n = ST_INHIBIT;
                end
            end
            ST_PARITY: begin
                if (fall) begin
                    if (sh_odd ^ kdat_s) state_n = ST_STOP;
                    else begin
                        bad_par = 1'b1;
                        state_n = ST_REARM;
                    end
                end else if (tmo_hit) begin
                    bad_tmo = 1'b1;
                    state_n = ST_INHIBIT;
                end
            end
            ST_STOP: begin
                if (fall) begin
                    if (kdat_s) begin
                        done_ok = 1'b1;
                        state_n = ST_INHIBIT;
                    end else begin
                        bad_stop = 1'b1;
                        state_n  = ST_REARM;
                    end
                end else if (tmo_hit) begin
                    bad_tmo = 1'b1;
                    state_n = ST_INHIBIT;
                end
            end
            ST_REARM: begin
                if (gap_done) state_n = ST_LISTEN;
            end
            default: state_n = ST_INHIBIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_INHIBIT;
        else        state <= state_n;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kclk_drv_low <= 1'b1;
            rx_byte      <= '0;
            rx_valid     <= 1'b0;
            rx_err       <= 1'b0;
            err_kind     <= ERR_NONE;
            resend_req   <= 1'b0;
        end else begin
            kclk_drv_low <= (state_n == ST_INHIBIT) || (state_n == ST_REARM);
            rx_valid     <= done_ok;
            rx_err       <= bad_par | bad_stop | bad_tmo;
            resend_req   <= bad_par | bad_stop;
            if (done_ok)  rx_byte  <= sh_data;
            if (bad_par)  err_kind <= ERR_PARITY;
            if (bad_stop) err_kind <= ERR_STOP;
            if (bad_tmo)  err_kind <= ERR_TIMEOUT;
        end
    end

    assign kdat_drv_low = 1'b0;
    assign resend_code  = DATA_BITS'(RESEND_CMD);
endmodule

// File: rtl/ps2rx_engine_chk.sv
module ps2rx_engine_chk
    import ps2rx_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         arm,
    input ps2rx_state_t state,
    input logic         kclk_drv_low,
    input logic [W-1:0] rx_byte,
    input logic         rx_valid,
    input logic         rx_err,
    input logic [1:0]   err_kind,
    input logic         resend_req
);
    AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kclk_drv_low) |-> ($past(arm) || $past(state) == ST_REARM)); // R2

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R8

    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_byte)); // R8

    AST_CLOCK_LOW_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> kclk_drv_low); // R8

    AST_NO_VALID_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_err)); // R5

    AST_ERR_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> err_kind != ERR_NONE); // R6

    AST_RESEND_ONLY_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
        resend_req |-> (rx_err && err_kind != ERR_TIMEOUT && kclk_drv_low)); // R7

    AST_TIMEOUT_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err && err_kind == ERR_TIMEOUT) |-> (kclk_drv_low && !resend_req)); // R9
endmodule

bind ps2rx_engine ps2rx_engine_chk #(.W(DATA_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .arm(arm), .state(state),
    .kclk_drv_low(kclk_drv_low), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_err(rx_err), .err_kind(err_kind), .resend_req(resend_req));

// File: tb/ps2rx_engine_tb.sv
`timescale 1ns/1ps
module ps2rx_engine_tb;
    localparam int HALF = 20;
    localparam int TMO  = 300;
    localparam int GAP  = 120;

    typedef struct packed {
        logic       err;
        logic [1:0] kind;
        logic [7:0] data;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0;
    logic dev_clk = 1'b1, dev_dat = 1'b1;
    logic kclk_drv_low, kdat_drv_low, rx_valid, rx_err, resend_req;
    logic [7:0] rx_byte, resend_code;
    logic [1:0] err_kind;
    logic kclk_line, kdat_line;

    int total = 0, bad = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    assign kclk_line = dev_clk & ~kclk_drv_low;
    assign kdat_line = dev_dat & ~kdat_drv_low;

    ps2rx_engine #(.TMO_CYCLES(TMO), .GAP_CYCLES(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .kclk_in(kclk_line), .kdat_in(kdat_line),
        .kclk_drv_low(kclk_drv_low), .kdat_drv_low(kdat_drv_low), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .rx_err(rx_err), .err_kind(err_kind),
        .resend_req(resend_req), .resend_code(resend_code));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fire_arm();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
    endtask

    task automatic dev_frame(input logic [7:0] b, input bit flip_par, input bit bad_stop,
                             input int nbits);
        logic [10:0] f;
        f = {~bad_stop, (~^b) ^ flip_par, b, 1'b0};
        while (kclk_drv_low) @(negedge clk);
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            dev_dat = f[i];
            repeat (HALF) @(negedge clk);
            dev_clk = 1'b0;
            repeat (HALF) @(negedge clk);
            dev_clk = 1'b1;
        end
        dev_dat = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic expect_item(input bit e, input logic [1:0] k, input logic [7:0] d);
        exp_t it;
        it.err = e; it.kind = k; it.data = d;
        q.push_back(it);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic good(input logic [7:0] b);
        expect_item(1'b0, 2'b00, b);
        fire_arm();
        dev_frame(b, 1'b0, 1'b0, 11);
        drain();
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (rx_valid || rx_err)) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R8 unexpected event", {rx_valid, rx_err}, 0);
                end else begin
                    exp_t it;
                    it = q.pop_front();
                    if (!it.err) begin
                        chk(rx_valid && !rx_err, "R4 strobe", {rx_valid, rx_err}, 2);
                        chk(rx_byte == it.data, "R4 byte", rx_byte, it.data);
                        chk(kclk_drv_low == 1'b1, "R8 clock low at strobe", kclk_drv_low, 1);
                    end else begin
                        chk(rx_err && !rx_valid, "R5 error strobe", {rx_valid, rx_err}, 1);
                        chk(err_kind == it.kind, "R6 err_kind", err_kind, it.kind);
                        chk(resend_req == (it.kind != 2'b11), "R9 resend_req", resend_req,
                            it.kind != 2'b11);
                        chk(resend_code == 8'hFE, "R7 resend_code", resend_code, 8'hFE);
                    end
                end
            end
        end
    end

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(kclk_drv_low == 1'b1, "R1 reset drive", kclk_drv_low, 1);
        chk(rx_valid == 1'b0 && rx_err == 1'b0, "R1 reset strobes", {rx_valid, rx_err}, 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        chk(kclk_drv_low == 1'b1, "R1 held before arm", kclk_drv_low, 1);
        chk(kdat_drv_low == 1'b0, "R10 data never driven", kdat_drv_low, 0);

        // R2 release and first good frame
        expect_item(1'b0, 2'b00, 8'hA5);
        fire_arm();
        @(negedge clk);
        chk(kclk_drv_low == 1'b0, "R2 release on arm", kclk_drv_low, 0);
        dev_frame(8'hA5, 1'b0, 1'b0, 11);
        drain();
        repeat (GAP + 20) @(negedge clk);
        chk(kclk_drv_low == 1'b1, "R8 stays inhibited", kclk_drv_low, 1);

        // R3 false start then real frame
        expect_item(1'b0, 2'b00, 8'h3C);
        fire_arm();
        repeat (HALF) @(negedge clk);
        dev_dat = 1'b1;
        dev_clk = 1'b0;
        repeat (HALF) @(negedge clk);
        dev_clk = 1'b1;
        repeat (HALF) @(negedge clk);
        chk(kclk_drv_low == 1'b0, "R3 still listening", kclk_drv_low, 0);
        chk(q.size() == 1, "R3 no event", q.size(), 1);
        dev_frame(8'h3C, 1'b0, 1'b0, 11);
        drain();

        // R4 bit order and parity patterns
        good(8'h01);
        good(8'h80);
        good(8'h00);
        good(8'hFF);

        // R5 parity error, R7 auto re-arm
        expect_item(1'b1, 2'b01, 8'h00);
        expect_item(1'b0, 2'b00, 8'h55);
        fire_arm();
        dev_frame(8'h55, 1'b1, 1'b0, 11);
        chk(kclk_drv_low == 1'b1, "R7 held after parity error", kclk_drv_low, 1);
        repeat (GAP) @(negedge clk);
        chk(kclk_drv_low == 1'b0, "R7 re-armed without arm", kclk_drv_low, 0);
        dev_frame(8'h55, 1'b0, 1'b0, 11);
        drain();

        // R6 stop error
        expect_item(1'b1, 2'b10, 8'h00);
        expect_item(1'b0, 2'b00, 8'h12);
        fire_arm();
        dev_frame(8'h12, 1'b0, 1'b1, 11);
        chk(kclk_drv_low == 1'b1, "R7 held after stop error", kclk_drv_low, 1);
        dev_frame(8'h12, 1'b0, 1'b0, 11);
        drain();
        chk(rx_byte == 8'h12, "R8 byte held", rx_byte, 8'h12);

        // R9 timeout
        expect_item(1'b1, 2'b11, 8'h00);
        fire_arm();
        dev_frame(8'h6B, 1'b0, 1'b0, 4);
        drain();
        chk(kclk_drv_low == 1'b1, "R9 inhibit after timeout", kclk_drv_low, 1);
        repeat (GAP + 40) @(negedge clk);
        chk(kclk_drv_low == 1'b1, "R9 no auto re-arm", kclk_drv_low, 1);
        chk(rx_byte == 8'h12, "R9 byte untouched", rx_byte, 8'h12);
        chk(kdat_drv_low == 1'b0, "R10 data never driven end", kdat_drv_low, 0);

        finish_up();
    end
endmodule